// File: doc/BRIEF.md
# Multicart Mapper Register File

This block holds the CPU-visible configuration state of a cartridge controller that lets one board stand in for several simple discrete-logic banking schemes. The console CPU first writes a register index into the $5000-$5FFF window, then writes a value anywhere in $8000-$FFFF; the value lands in whichever of the four internal registers the index names. Two of those registers are per-game (a CHR bank and an inner PRG bank), the other two are set once by a menu program (a mode word and an outer PRG bank).

The block runs on a fast system clock and oversamples the CPU phase clock M2. Address-window hits and the data byte are captured while M2 is high and committed on the falling edge of M2. It drives the two upper CHR RAM address bits and the nametable RAM A10 select from the PPU address, and exports the mode and bank fields to a separate PRG address generator. A dedicated power-on input is the only thing that initialises the registers; a console reset leaves them alone.

Top module: `mcart_regfile`

## Requirements
- R1: A CPU write (cpu_rw low) with romsel_n high and cpu_a_hi = 3'b101 (address $5000-$5FFF) loads the index; data bit 7 picks the group (0 per-game, 1 supervisor) and data bit 0 picks the register inside it; other data bits are don't-care.
- R2: A CPU write with romsel_n low (address $8000-$FFFF) stores the data into the indexed register: index {0,0} CHR bank, {0,1} inner bank, {1,0} mode, {1,1} outer bank.
- R3: The CHR bank register keeps data bits 1..0 and drives chr_bank_o.
- R4: The inner bank register keeps data bits 3..0 and drives inner_bank_o.
- R5: The mode register keeps data bits 5..0: bits 1..0 appear on mirror_mode_o, bits 3..2 on prg_mode_o, bits 5..4 on outer_size_o.
- R6: The outer bank register keeps data bits 5..0 and drives outer_bank_o.
- R7: While mirror_mode_o is 0 or 1, a data write to the CHR bank or inner bank register also copies data bit 4 into mirror_mode_o bit 0.
- R8: While mirror_mode_o is 2 or 3, data bit 4 of a CHR bank or inner bank write leaves the mirroring mode unchanged.
- R9: ciram_a10_o is 0 in mirroring mode 0, 1 in mode 1, PPU A10 in mode 2 (vertical) and PPU A11 in mode 3 (horizontal).
- R10: CPU reads, and writes outside both windows (romsel_n high with cpu_a_hi other than 3'b101), change no register.
- R11: A write takes effect only after M2 falls; while M2 is still high the outputs keep their previous values.
- R12: With por high, outer_bank_o becomes all ones, prg_mode_o 3, and chr bank, inner bank, outer size, mirroring mode and index zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than M2 |
| por | input | 1 | Synchronous active-high power-on initialise |
| m2 | input | 1 | CPU phase clock M2 |
| cpu_rw | input | 1 | CPU read/write, low for write |
| romsel_n | input | 1 | Active-low ROM select (A15 and M2) |
| cpu_a_hi | input | 3 | CPU address bits 14..12 |
| cpu_d | input | 8 | CPU data bus |
| ppu_a_nt | input | 2 | PPU address bits {A11, A10} |
| chr_bank_o | output | CHR_W | CHR RAM upper address bits |
| ciram_a10_o | output | 1 | Nametable RAM A10 select |
| inner_bank_o | output | INNER_W | Inner PRG bank |
| outer_bank_o | output | OUTER_W | Outer PRG bank |
| prg_mode_o | output | 2 | PRG bank mode |
| outer_size_o | output | 2 | PRG outer bank size |
| mirror_mode_o | output | 2 | Nametable mirroring mode |

## Verification
The hardest situation to reach is the bit-4 redirect crossing mirroring classes: a per-game write must land while the mode register already holds a one-screen value, and then again after the supervisor mode write has switched to vertical or horizontal, with an index change in between. Directed sequences walk through mode 0, 1, 2 and 3 with CHR and inner writes carrying both values of bit 4, and a seeded random mix of index writes, data writes, out-of-window writes and reads keeps revisiting those transitions while a bench model tracks every register.

// File: rtl/mcart_pkg.sv
package mcart_pkg;

    // Nametable arrangement selected by the low two mode bits
    typedef enum logic [1:0] {
        MIR_SCR_LO = 2'd0,
        MIR_SCR_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mir_e;

    // Mode word, packed in the bit order the CPU writes it
    typedef struct packed {
        logic [1:0] size;
        logic [1:0] prg;
        mir_e       mir;
    } mode_t;

    // Register index: {group, member}
    typedef enum logic [1:0] {
        SEL_CHR   = 2'b00,
        SEL_INNER = 2'b01,
        SEL_MODE  = 2'b10,
        SEL_OUTER = 2'b11
    } sel_e;

    // One committed CPU write
    typedef struct packed {
        logic       idx_we;
        logic       dat_we;
        logic [7:0] data;
    } wr_t;

    localparam int unsigned REDIR_BIT   = 4;
    localparam logic [2:0]  IDX_WINDOW  = 3'b101;
    localparam logic [1:0]  PRG_PWRUP   = 2'd3;

    function automatic logic nt_a10(input mir_e m, input logic a11, input logic a10);
        unique case (m)
            MIR_SCR_LO: return 1'b0;
            MIR_SCR_HI: return 1'b1;
            MIR_VERT:   return a10;
            default:    return a11;
        endcase
    endfunction

endpackage

// File: rtl/mcart_bus_decode.sv
module mcart_bus_decode
    import mcart_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  logic       m2,
    input  logic       cpu_rw,
    input  logic       romsel_n,
    input  logic [2:0] cpu_a_hi,
    input  logic [7:0] cpu_d,
    output wr_t        wr
);

    logic m2_q;
    wr_t  pend_q;
    wr_t  hit;

    always_comb begin
        hit.idx_we = !cpu_rw && romsel_n && (cpu_a_hi == IDX_WINDOW);
        hit.dat_we = !cpu_rw && !romsel_n;
        hit.data   = cpu_d;
    end

    // Capture while M2 is high; the last high sample is committed at the fall
    always_ff @(posedge clk) begin
        if (por) begin
            m2_q   <= 1'b0;
            pend_q <= '0;
        end else begin
            m2_q <= m2;
            if (m2) pend_q <= hit;
        end
    end

    assign wr = (m2_q && !m2) ? pend_q : '0;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (por)
        !(wr.idx_we && wr.dat_we)) else $error("both strobes"); // R2

    AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (por)
        (wr.idx_we || wr.dat_we) |-> (!m2 && $past(m2))) else $error("commit off M2 fall"); // R11

endmodule

// File: rtl/mcart_state_regs.sv
module mcart_state_regs
    import mcart_pkg::*;
#(
    parameter int unsigned CHR_W   = 2,
    parameter int unsigned INNER_W = 4,
    parameter int unsigned OUTER_W = 6
) (
    input  logic               clk,
    input  logic               por,
    input  wr_t                wr,
    output logic [CHR_W-1:0]   chr_q,
    output logic [INNER_W-1:0] inner_q,
    output logic [OUTER_W-1:0] outer_q,
    output mode_t              mode_q
);

    sel_e sel_q;
    logic per_game;

    assign per_game = (sel_q == SEL_CHR) || (sel_q == SEL_INNER);

    always_ff @(posedge clk) begin
        if (por) begin
            sel_q   <= SEL_CHR;
            chr_q   <= '0;
            inner_q <= '0;
            outer_q <= '1;
            mode_q  <= '{size: 2'd0, prg: PRG_PWRUP, mir: MIR_SCR_LO};
        end else begin
            if (wr.idx_we)
                sel_q <= sel_e'({wr.data[7], wr.data[0]});
            if (wr.dat_we) begin
                unique case (sel_q)
                    SEL_CHR:   chr_q   <= wr.data[CHR_W-1:0];
                    SEL_INNER: inner_q <= wr.data[INNER_W-1:0];
                    SEL_MODE:  mode_q  <= mode_t'(wr.data[5:0]);
                    default:   outer_q <= wr.data[OUTER_W-1:0];
                endcase
                // One-screen select shadowed by per-game writes
                if (per_game && !mode_q.mir[1])
                    mode_q.mir <= mir_e'({1'b0, wr.data[REDIR_BIT]});
            end
        end
    end

    AST_D4_COPY: assert property (@(posedge clk) disable iff (por)
        (wr.dat_we && per_game && !mode_q.mir[1])
        |=> (mode_q.mir == mir_e'({1'b0, $past(wr.data[REDIR_BIT])})))
        else $error("bit4 not redirected"); // R7

    AST_D4_IGNORED: assert property (@(posedge clk) disable iff (por)
        (wr.dat_we && per_game && mode_q.mir[1]) |=> $stable(mode_q))
        else $error("bit4 leaked into mode"); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (por)
        !(wr.idx_we || wr.dat_we)
        |=> ($stable(chr_q) && $stable(inner_q) && $stable(outer_q) && $stable(mode_q) && $stable(sel_q)))
        else $error("state moved without a write"); // R10

    AST_POR_INIT: assert property (@(posedge clk) disable iff (por)
        $fell(por) |-> (outer_q == '1 && mode_q.prg == PRG_PWRUP && sel_q == SEL_CHR))
        else $error("power-on state"); // R12

endmodule

// File: rtl/mcart_nt_mux.sv
module mcart_nt_mux
    import mcart_pkg::*;
(
    input  mir_e       mir,
    input  logic [1:0] ppu_a_nt,
    output logic       ciram_a10
);

    assign ciram_a10 = nt_a10(mir, ppu_a_nt[1], ppu_a_nt[0]);

endmodule

// File: rtl/mcart_regfile.sv
module mcart_regfile
    import mcart_pkg::*;
#(
    parameter int unsigned CHR_W   = 2,
    parameter int unsigned INNER_W = 4,
    parameter int unsigned OUTER_W = 6
) (
    input  logic               clk,
    input  logic               por,
    input  logic               m2,
    input  logic               cpu_rw,
    input  logic               romsel_n,
    input  logic [2:0]         cpu_a_hi,
    input  logic [7:0]         cpu_d,
    input  logic [1:0]         ppu_a_nt,
    output logic [CHR_W-1:0]   chr_bank_o,
    output logic               ciram_a10_o,
    output logic [INNER_W-1:0] inner_bank_o,
    output logic [OUTER_W-1:0] outer_bank_o,
    output logic [1:0]         prg_mode_o,
    output logic [1:0]         outer_size_o,
    output logic [1:0]         mirror_mode_o
);

    wr_t   wr;
    mode_t mode;

    mcart_bus_decode u_decode (
        .clk      (clk),
        .por      (por),
        .m2       (m2),
        .cpu_rw   (cpu_rw),
        .romsel_n (romsel_n),
        .cpu_a_hi (cpu_a_hi),
        .cpu_d    (cpu_d),
        .wr       (wr)
    );

    mcart_state_regs #(
        .CHR_W   (CHR_W),
        .INNER_W (INNER_W),
        .OUTER_W (OUTER_W)
    ) u_regs (
        .clk     (clk),
        .por     (por),
        .wr      (wr),
        .chr_q   (chr_bank_o),
        .inner_q (inner_bank_o),
        .outer_q (outer_bank_o),
        .mode_q  (mode)
    );

    mcart_nt_mux u_nt (
        .mir       (mode.mir),
        .ppu_a_nt  (ppu_a_nt),
        .ciram_a10 (ciram_a10_o)
    );

    assign prg_mode_o    = mode.prg;
    assign outer_size_o  = mode.size;
    assign mirror_mode_o = mode.mir;

    AST_SCREEN_FIXED: assert property (@(posedge clk) disable iff (por)
        (mirror_mode_o == 2'd0) |-> !ciram_a10_o) else $error("one-screen low"); // R9

    AST_SETTLED_IN_M2: assert property (@(posedge clk) disable iff (por)
        (m2 && $past(m2)) |=> ($stable(chr_bank_o) && $stable(outer_bank_o))) else $error("early commit"); // R11

endmodule

// File: tb/mcart_regfile_tb_top.sv
module mcart_regfile_tb_top;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       m2 = 1'b0;
    logic       cpu_rw = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0] data = 8'h00;
    logic [1:0] ppu = 2'b00;
    logic       romsel_n;

    logic [1:0] chr_o, prg_o, size_o, mir_o;
    logic [3:0] inner_o;
    logic [5:0] outer_o;
    logic       ciram_o;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [1:0] m_sel;
    logic [1:0] m_chr, m_mir, m_prg, m_size;
    logic [3:0] m_inner;
    logic [5:0] m_outer;

    always #2.5 clk = ~clk;
    assign romsel_n = !(addr[15] && m2);

    mcart_regfile dut_i (
        .clk          (clk),
        .por          (por),
        .m2           (m2),
        .cpu_rw       (cpu_rw),
        .romsel_n     (romsel_n),
        .cpu_a_hi     (addr[14:12]),
        .cpu_d        (data),
        .ppu_a_nt     (ppu),
        .chr_bank_o   (chr_o),
        .ciram_a10_o  (ciram_o),
        .inner_bank_o (inner_o),
        .outer_bank_o (outer_o),
        .prg_mode_o   (prg_o),
        .outer_size_o (size_o),
        .mirror_mode_o(mir_o)
    );

    function automatic logic exp_a10(input logic [1:0] m, input logic [1:0] p);
        case (m)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return p[0];
            default: return p[1];
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "chr", chr_o, m_chr);
        chk(req, "inner", inner_o, m_inner);
        chk(req, "outer", outer_o, m_outer);
        chk(req, "prg_mode", prg_o, m_prg);
        chk(req, "size", size_o, m_size);
        chk(req, "mirror", mir_o, m_mir);
        for (int p = 0; p < 4; p++) begin
            ppu = p[1:0];
            #0.5;
            chk("R9", "ciram", ciram_o, exp_a10(m_mir, ppu));
        end
    endtask

    function automatic void model_op(input logic [15:0] a, input logic [7:0] d, input logic rd);
        if (rd) return;
        if (a[15]) begin
            case (m_sel)
                2'b00: m_chr = d[1:0];
                2'b01: m_inner = d[3:0];
                2'b10: {m_size, m_prg, m_mir} = d[5:0];
                default: m_outer = d[5:0];
            endcase
            if (!m_sel[1] && !m_mir[1]) m_mir = {1'b0, d[4]};
        end else if (a[14:12] == 3'b101) begin
            m_sel = {d[7], d[0]};
        end
    endfunction

    task automatic bus_op(input logic [15:0] a, input logic [7:0] d, input logic rd);
        @(negedge clk);
        addr = a; data = d; cpu_rw = rd; m2 = 1'b1;
        repeat (3) @(negedge clk);
        m2 = 1'b0;
        repeat (2) @(negedge clk);
        cpu_rw = 1'b1;
        model_op(a, d, rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sel = 2'b00; m_chr = 0; m_inner = 0; m_outer = 6'h3F;
        m_prg = 2'd3; m_size = 0; m_mir = 0;
        repeat (4) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        check_all("R12");

        // R3, R7: CHR write in mode 0 with bit4=1 -> mode 1
        bus_op(16'h5000, 8'h00, 1'b0);
        bus_op(16'h8000, 8'h13, 1'b0);
        check_all("R3");
        chk("R7", "mirror", mir_o, 1);
        // R4, R7: inner write, index via $5ABC, bit4=0 -> mode 0
        bus_op(16'h5ABC, 8'h01, 1'b0);
        bus_op(16'hC123, 8'h0A, 1'b0);
        check_all("R4");
        chk("R7", "mirror", mir_o, 0);
        // R5: supervisor mode write -> size3 prg3 vertical
        bus_op(16'h5FFF, 8'h80, 1'b0);
        bus_op(16'hFFFF, 8'hFE, 1'b0);
        check_all("R5");
        // R8: per-game writes with bit4 do not touch vertical mode
        bus_op(16'h5000, 8'h7E, 1'b0);
        bus_op(16'h9000, 8'h12, 1'b0);
        check_all("R8");
        chk("R8", "mirror", mir_o, 2);
        // R6, R1: index 0xFF selects outer bank
        bus_op(16'h5555, 8'hFF, 1'b0);
        bus_op(16'hA000, 8'h15, 1'b0);
        check_all("R6");
        chk("R1", "outer", outer_o, 6'h15);
        // R2: switch back to mode word, horizontal
        bus_op(16'h5001, 8'h80, 1'b0);
        bus_op(16'h8001, 8'h07, 1'b0);
        check_all("R2");
        // R10: outside window and reads ignored
        bus_op(16'h6000, 8'h01, 1'b0);
        bus_op(16'h4FFF, 8'h81, 1'b0);
        bus_op(16'h5000, 8'h01, 1'b1);
        bus_op(16'h8000, 8'h33, 1'b1);
        bus_op(16'h8000, 8'h0B, 1'b0);
        check_all("R10");
        chk("R10", "prg_mode", prg_o, 2);
        // R11: mid-write with M2 high, no change yet
        @(negedge clk);
        addr = 16'h8000; data = 8'h3C; cpu_rw = 1'b0; m2 = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "size", size_o, m_size);
        chk("R11", "mirror", mir_o, m_mir);
        m2 = 1'b0;
        repeat (2) @(negedge clk);
        cpu_rw = 1'b1;
        model_op(16'h8000, 8'h3C, 1'b0);
        check_all("R11");
        // R7 with mode 1 reached through mode word, then CHR clears it
        bus_op(16'h8000, 8'h01, 1'b0);
        bus_op(16'h5000, 8'h00, 1'b0);
        bus_op(16'h8000, 8'h02, 1'b0);
        check_all("R7");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          kind;
            kind = $urandom % 5;
            d = 8'($urandom);
            case (kind)
                0: a = 16'h5000 | 16'($urandom % 16'h1000);
                1, 2: a = 16'h8000 | 16'($urandom % 16'h8000);
                3: a = ($urandom % 2) ? 16'($urandom % 16'h5000) : (16'h6000 | 16'($urandom % 16'h2000));
                default: a = 16'($urandom);
            endcase
            bus_op(a, d, kind == 4);
            check_all("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule